// File: doc/BRIEF.md
# Dual-Channel Trigger Timestamp Capture with Event Interrupt

This block records the value of a free-running 64-bit time count whenever one of two external trigger pins shows a rising edge. Each trigger is brought into the clock domain through a short flop chain before its edge is detected. Every channel keeps its captured values in its own small queue. A status register tells software which channels hold unread values. Software fetches a value as two 32-bit words, the lower one first, and keeps fetching while the channel's status bit stays high.

Alongside the capture path sits a small interrupt unit. An event register holds one bit per capture channel and one bit for a periodic pulse that another block produces. A mask register selects which of those bits may raise the interrupt line. Event bits are cleared by writing ones to them. A driver enabling a source first clears that source's event bit and only then unmasks it, so an old event cannot fire the line. A build option reduces each queue to a single holding register.

Top module: `tstamp_capture`

## Requirements
- R1: Each trigger passes through two synchronizing flops. A low-to-high change captures the time count that is present at the third rising clock edge after the pin goes high, so the stored value is the count seen at the pin change plus two. A pin that stays high, or a falling edge, captures nothing further.
- R2: Each channel queues up to DEPTH captures and returns them oldest first.
- R3: The status register (address 0) has bit 0 for channel 0 and bit 1 for channel 1. A bit is 1 while that channel holds at least one unread capture. The two channels are independent of each other.
- R4: A capture on channel 0 or channel 1 sets event bit 0 or event bit 1 of the event register (address 1).
- R5: When a channel queue already holds DEPTH entries, further captures are dropped and the stored entries stay unchanged.
- R6: The mask register (address 2) uses the same bit positions as the event register. The interrupt output is 1 exactly when some event bit and its mask bit are both 1. After reset, the event register, the mask register and the interrupt are all 0.
- R7: Writing a 1 to an event bit clears that bit.
- R8: Writing a 0 to an event bit leaves it unchanged.
- R9: A one-cycle pulse on pulse_evt sets event bit 2.
- R10: Channel 0's low and high words are at addresses 3 and 4, and channel 1's are at addresses 5 and 6. Both are read with bus_rd high. A low read returns the head entry's low word (0 when the queue is empty) and stores the head's high word. A high read returns that stored word and removes the head entry. A low read on its own removes nothing.
- R11: If a stale event bit is cleared first and its mask bit is set afterwards, the interrupt stays low.
- R12: With FIFO_EN = 0, each channel holds a single capture. The first capture is kept and later ones are dropped until it has been read.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| trig_in | input | 2 | Asynchronous trigger pins, one per channel |
| time_cnt | input | 2*WORD_W | Current time count |
| pulse_evt | input | 1 | One-cycle periodic pulse event |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe, which gives timestamp reads their side effects |
| bus_addr | input | 3 | Register select |
| bus_wdata | input | WORD_W | Write data |
| bus_rdata | output | WORD_W | Read data for the selected register, combinational |
| irq | output | 1 | Interrupt request |

## Verification
The hardest state to reach from the ports is a full queue that receives more edges. Reaching it takes DEPTH plus one separate rise-and-fall pulses on one pin, with no pops in between, and every pulse must last longer than the synchronizer delay. The bench fires five such pulses and records the time count at each pin change. It then drains the queue and compares each word pair against the recorded count plus two, so a dropped or overwritten entry shows up as a wrong value or an extra valid bit. A second instance built without the queue sees the same trigger pins, which shows that only its first capture is kept. The masked-stale-event ordering is driven from a vector table of register writes and interrupt samples.

// File: rtl/tstamp_pkg.sv
package tstamp_pkg;
  localparam int NUM_CH    = 2;
  localparam int NUM_EVT   = 3;
  localparam int EVT_PULSE = 2;

  typedef enum logic [2:0] {
    REG_STATUS = 3'd0,
    REG_EVENT  = 3'd1,
    REG_MASK   = 3'd2,
    REG_CH0_LO = 3'd3,
    REG_CH0_HI = 3'd4,
    REG_CH1_LO = 3'd5,
    REG_CH1_HI = 3'd6
  } reg_sel_e;

  function automatic logic [2:0] lo_sel(input int ch);
    return 3'(3 + 2 * ch);
  endfunction

  function automatic logic [2:0] hi_sel(input int ch);
    return 3'(4 + 2 * ch);
  endfunction
endpackage

// File: rtl/tstamp_rst_sync.sv
module tstamp_rst_sync (
  input  logic clk,
  input  logic arst_n,
  output logic rst_n_o
);
  logic [1:0] chain_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) chain_q <= 2'b00;
    else         chain_q <= {chain_q[0], 1'b1};
  end

  assign rst_n_o = chain_q[1];
endmodule

// File: rtl/tstamp_edge_sync.sv
module tstamp_edge_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic async_in,
  output logic rise
);
  logic [STAGES:0] sh_q, sh_d;

  always_comb sh_d = {sh_q[STAGES-1:0], async_in};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh_q <= '0;
    else        sh_q <= sh_d;
  end

  // rising edge between the last synchronized stage and the history stage
  assign rise = sh_q[STAGES-1] & ~sh_q[STAGES];
endmodule

// File: rtl/tstamp_fifo.sv
module tstamp_fifo #(
  parameter int W       = 64,
  parameter int DEPTH   = 4,
  parameter int FIFO_EN = 1
) (
  input  logic                                          clk,
  input  logic                                          rst_n,
  input  logic                                          push,
  input  logic                                          pop,
  input  logic [W-1:0]                                  din,
  output logic [W-1:0]                                  head,
  output logic [$clog2(((FIFO_EN != 0) ? DEPTH : 1) + 1)-1:0] fill
);
  localparam int EFF = (FIFO_EN != 0) ? DEPTH : 1;
  localparam int CW  = $clog2(EFF + 1);

  logic [CW-1:0] fill_q, fill_d;
  logic          do_push, do_pop;

  // a full queue refuses the push even when a pop happens in the same cycle
  always_comb begin
    do_push = push && (fill_q != CW'(EFF));
    do_pop  = pop  && (fill_q != '0);
    fill_d  = fill_q;
    case ({do_push, do_pop})
      2'b10:   fill_d = fill_q + 1'b1;
      2'b01:   fill_d = fill_q - 1'b1;
      default: fill_d = fill_q;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) fill_q <= '0;
    else        fill_q <= fill_d;
  end

  assign fill = fill_q;

  generate
    if (EFF == 1) begin : gen_single
      logic [W-1:0] hold_q;

      always_ff @(posedge clk) begin
        if (do_push) hold_q <= din;
      end

      assign head = hold_q;
    end else begin : gen_ring
      localparam int PW = $clog2(EFF);

      logic [W-1:0]  mem [EFF];
      logic [PW-1:0] wp_q, wp_d, rp_q, rp_d;

      function automatic logic [PW-1:0] bump(input logic [PW-1:0] p);
        if (p == PW'(EFF - 1)) return '0;
        return p + 1'b1;
      endfunction

      always_comb begin
        wp_d = do_push ? bump(wp_q) : wp_q;
        rp_d = do_pop  ? bump(rp_q) : rp_q;
      end

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          wp_q <= '0;
          rp_q <= '0;
        end else begin
          wp_q <= wp_d;
          rp_q <= rp_d;
        end
      end

      always_ff @(posedge clk) begin
        if (do_push) mem[wp_q] <= din;
      end

      assign head = mem[rp_q];
    end
  endgenerate
endmodule

// File: rtl/tstamp_event_regs.sv
module tstamp_event_regs #(
  parameter int N = 3
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] set,
  input  logic [N-1:0] clr,
  input  logic         mask_we,
  input  logic [N-1:0] mask_din,
  output logic [N-1:0] evt,
  output logic [N-1:0] mask,
  output logic         irq
);
  logic [N-1:0] evt_q, evt_d, mask_q, mask_d;

  // a new event in the same cycle as its clear survives
  always_comb begin
    evt_d  = (evt_q & ~clr) | set;
    mask_d = mask_we ? mask_din : mask_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      evt_q  <= '0;
      mask_q <= '0;
    end else begin
      evt_q  <= evt_d;
      mask_q <= mask_d;
    end
  end

  assign evt  = evt_q;
  assign mask = mask_q;
  assign irq  = |(evt_q & mask_q);
endmodule

// File: rtl/tstamp_capture.sv
module tstamp_capture
  import tstamp_pkg::*;
#(
  parameter int WORD_W      = 32,
  parameter int DEPTH       = 4,
  parameter int FIFO_EN     = 1,
  parameter int SYNC_STAGES = 2
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [NUM_CH-1:0]     trig_in,
  input  logic [2*WORD_W-1:0]   time_cnt,
  input  logic                  pulse_evt,
  input  logic                  bus_wr,
  input  logic                  bus_rd,
  input  logic [2:0]            bus_addr,
  input  logic [WORD_W-1:0]     bus_wdata,
  output logic [WORD_W-1:0]     bus_rdata,
  output logic                  irq
);
  localparam int CNT_W     = 2 * WORD_W;
  localparam int EFF_DEPTH = (FIFO_EN != 0) ? DEPTH : 1;
  localparam int FILL_W    = $clog2(EFF_DEPTH + 1);

  logic                              rst_sync_n;
  logic [NUM_CH-1:0]                 trig_rise;
  logic [NUM_CH-1:0]                 ch_vld;
  logic [NUM_CH-1:0]                 rd_lo;
  logic [NUM_CH-1:0]                 rd_hi;
  logic [NUM_CH-1:0]                 snap_en;
  logic [NUM_CH-1:0][FILL_W-1:0]     fill;
  logic [NUM_CH-1:0][CNT_W-1:0]      head;
  logic [WORD_W-1:0]                 snap_q [NUM_CH];
  logic [WORD_W-1:0]                 snap_d [NUM_CH];
  logic [NUM_EVT-1:0]                evt_set, evt_clr, evt_q, mask_q;
  logic                              mask_we;

  tstamp_rst_sync u_rst (
    .clk     (clk),
    .arst_n  (rst_n),
    .rst_n_o (rst_sync_n)
  );

  genvar g;
  generate
    for (g = 0; g < NUM_CH; g++) begin : gen_ch
      tstamp_edge_sync #(.STAGES(SYNC_STAGES)) u_edge (
        .clk      (clk),
        .rst_n    (rst_sync_n),
        .async_in (trig_in[g]),
        .rise     (trig_rise[g])
      );

      tstamp_fifo #(.W(CNT_W), .DEPTH(DEPTH), .FIFO_EN(FIFO_EN)) u_fifo (
        .clk   (clk),
        .rst_n (rst_sync_n),
        .push  (trig_rise[g]),
        .pop   (rd_hi[g]),
        .din   (time_cnt),
        .head  (head[g]),
        .fill  (fill[g])
      );

      assign ch_vld[g]  = (fill[g] != '0);
      assign rd_lo[g]   = bus_rd && (bus_addr == lo_sel(g));
      assign rd_hi[g]   = bus_rd && (bus_addr == hi_sel(g));
      assign snap_en[g] = rd_lo[g] && ch_vld[g];

      // high word of the head entry, frozen by the low-word read
      always_comb snap_d[g] = snap_en[g] ? head[g][CNT_W-1:WORD_W] : snap_q[g];

      always_ff @(posedge clk or negedge rst_sync_n) begin
        if (!rst_sync_n) snap_q[g] <= '0;
        else             snap_q[g] <= snap_d[g];
      end
    end
  endgenerate

  assign evt_set = {pulse_evt, trig_rise};
  assign evt_clr = (bus_wr && (bus_addr == REG_EVENT)) ? bus_wdata[NUM_EVT-1:0] : '0;
  assign mask_we = bus_wr && (bus_addr == REG_MASK);

  tstamp_event_regs #(.N(NUM_EVT)) u_evt (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .set      (evt_set),
    .clr      (evt_clr),
    .mask_we  (mask_we),
    .mask_din (bus_wdata[NUM_EVT-1:0]),
    .evt      (evt_q),
    .mask     (mask_q),
    .irq      (irq)
  );

  always_comb begin
    bus_rdata = '0;
    case (bus_addr)
      REG_STATUS: bus_rdata[NUM_CH-1:0]  = ch_vld;
      REG_EVENT:  bus_rdata[NUM_EVT-1:0] = evt_q;
      REG_MASK:   bus_rdata[NUM_EVT-1:0] = mask_q;
      REG_CH0_LO: bus_rdata = ch_vld[0] ? head[0][WORD_W-1:0] : '0;
      REG_CH0_HI: bus_rdata = snap_q[0];
      REG_CH1_LO: bus_rdata = ch_vld[1] ? head[1][WORD_W-1:0] : '0;
      REG_CH1_HI: bus_rdata = snap_q[1];
      default:    bus_rdata = '0;
    endcase
  end
endmodule

// File: rtl/tstamp_capture_chk.sv
module tstamp_capture_chk #(
  parameter int EFF = 4,
  parameter int CW  = 3
) (
  input logic          clk,
  input logic          rst_n,
  input logic [1:0]    rise,
  input logic [1:0]    vld,
  input logic [2:0]    evt,
  input logic [2:0]    mask,
  input logic          irq,
  input logic          pulse_evt,
  input logic          bus_wr,
  input logic          bus_rd,
  input logic [2:0]    bus_addr,
  input logic [2:0]    wbits,
  input logic [CW-1:0] fill0,
  input logic [CW-1:0] fill1
);
  assert_capture_sets_valid_R3: assert property (@(posedge clk) disable iff (!rst_n)
    rise[0] |=> vld[0]);

  assert_capture_sets_event_R4: assert property (@(posedge clk) disable iff (!rst_n)
    rise[1] |=> evt[1]);

  assert_no_overflow_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (fill0 <= CW'(EFF)) && (fill1 <= CW'(EFF)));

  assert_mask_gates_irq_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (mask == 3'b000) |-> !irq);

  assert_one_clears_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == 3'd1 && wbits[0] && !rise[0]) |=> !evt[0]);

  assert_zero_keeps_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == 3'd1 && !wbits[2] && evt[2]) |=> evt[2]);

  assert_pulse_event_R9: assert property (@(posedge clk) disable iff (!rst_n)
    pulse_evt |=> evt[2]);

  assert_high_read_pops_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && bus_addr == 3'd4 && fill0 != '0 && !rise[0]) |=> (fill0 == CW'($past(fill0) - 1'b1)));
endmodule

bind tstamp_capture tstamp_capture_chk #(.EFF(EFF_DEPTH), .CW(FILL_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_sync_n),
  .rise      (trig_rise),
  .vld       (ch_vld),
  .evt       (evt_q),
  .mask      (mask_q),
  .irq       (irq),
  .pulse_evt (pulse_evt),
  .bus_wr    (bus_wr),
  .bus_rd    (bus_rd),
  .bus_addr  (bus_addr),
  .wbits     (bus_wdata[2:0]),
  .fill0     (fill[0]),
  .fill1     (fill[1])
);

// File: tb/tstamp_capture_test.sv
`timescale 1ns/1ps
module tstamp_capture_test;
  import tstamp_pkg::*;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [1:0]  trig;
  logic [63:0] time_cnt;
  logic        pulse_evt;
  logic        bus_wr, bus_rd;
  logic [2:0]  bus_addr;
  logic [31:0] bus_wdata, bus_rdata;
  logic        irq;
  logic        s_wr, s_rd;
  logic [2:0]  s_addr;
  logic [31:0] s_rdata;
  logic        s_irq;

  int nchk  = 0;
  int nfail = 0;

  always #2.5 clk = ~clk;

  initial time_cnt = 64'h0000_0007_FFFF_FFF8;
  always @(posedge clk) time_cnt <= #1 time_cnt + 64'd1;

  tstamp_capture uut (
    .clk(clk), .rst_n(rst_n), .trig_in(trig), .time_cnt(time_cnt), .pulse_evt(pulse_evt),
    .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .irq(irq)
  );

  tstamp_capture #(.FIFO_EN(0)) uut_single (
    .clk(clk), .rst_n(rst_n), .trig_in(trig), .time_cnt(time_cnt), .pulse_evt(pulse_evt),
    .bus_wr(s_wr), .bus_rd(s_rd), .bus_addr(s_addr), .bus_wdata(32'd0),
    .bus_rdata(s_rdata), .irq(s_irq)
  );

  typedef struct packed {
    logic [1:0] kind;   // 0 write, 1 read and compare, 2 pulse, 3 irq compare
    logic [2:0] addr;
    logic [2:0] data;   // write data or expected value
    logic [3:0] req;
  } vec_t;

  localparam int NVEC = 22;
  localparam vec_t VEC [NVEC] = '{
    '{2'd2, 3'd0, 3'd0, 4'd9},   // R9 pulse
    '{2'd1, 3'd1, 3'd4, 4'd9},   // R9 bit 2 set
    '{2'd3, 3'd0, 3'd0, 4'd6},   // R6 masked, no irq
    '{2'd0, 3'd2, 3'd4, 4'd6},   // unmask pulse
    '{2'd3, 3'd0, 3'd1, 4'd6},   // R6 irq high
    '{2'd0, 3'd1, 3'd3, 4'd8},   // zero on bit 2
    '{2'd1, 3'd1, 3'd4, 4'd8},   // R8 still set
    '{2'd3, 3'd0, 3'd1, 4'd8},   // R8 irq held
    '{2'd0, 3'd1, 3'd4, 4'd7},   // one on bit 2
    '{2'd1, 3'd1, 3'd0, 4'd7},   // R7 cleared
    '{2'd3, 3'd0, 3'd0, 4'd7},   // R7 irq low
    '{2'd1, 3'd2, 3'd4, 4'd6},   // R6 mask readback
    '{2'd0, 3'd2, 3'd0, 4'd11},  // mask off
    '{2'd2, 3'd0, 3'd0, 4'd11},  // stale pulse
    '{2'd3, 3'd0, 3'd0, 4'd6},   // R6 masked stale
    '{2'd0, 3'd1, 3'd4, 4'd11},  // clear first
    '{2'd0, 3'd2, 3'd4, 4'd11},  // then unmask
    '{2'd3, 3'd0, 3'd0, 4'd11},  // R11 no irq
    '{2'd2, 3'd0, 3'd0, 4'd11},  // fresh pulse
    '{2'd3, 3'd0, 3'd1, 4'd6},   // R6 fresh event fires
    '{2'd0, 3'd1, 3'd4, 4'd7},   // tidy
    '{2'd0, 3'd2, 3'd0, 4'd6}    // tidy
  };

  task automatic report;
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
  endtask

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bwrite(input logic [2:0] a, input logic [31:0] d);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic bread(input logic [2:0] a, input logic rd, output logic [31:0] v);
    bus_addr = a; bus_rd = rd;
    #1 v = bus_rdata;
    @(negedge clk);
    bus_rd = 1'b0;
  endtask

  task automatic sread(input logic [2:0] a, input logic rd, output logic [31:0] v);
    s_addr = a; s_rd = rd;
    #1 v = s_rdata;
    @(negedge clk);
    s_rd = 1'b0;
  endtask

  task automatic fire(input int ch, output logic [63:0] t);
    t = time_cnt;
    trig[ch] = 1'b1;
    step(5);
    trig[ch] = 1'b0;
    step(5);
  endtask

  task automatic rd_ts(input int ch, output logic [63:0] v);
    logic [31:0] lo, hi;
    bread(lo_sel(ch), 1'b1, lo);
    bread(hi_sel(ch), 1'b1, hi);
    v = {hi, lo};
  endtask

  task automatic srd_ts(input int ch, output logic [63:0] v);
    logic [31:0] lo, hi;
    sread(lo_sel(ch), 1'b1, lo);
    sread(hi_sel(ch), 1'b1, hi);
    v = {hi, lo};
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    nfail++;
    $display("FAIL watchdog expired actual=hung expected=done");
    report();
    $finish;
  end

  initial begin
    logic [31:0] v, v2;
    logic [63:0] ts, t0;
    logic [63:0] tl [5];
    rst_n = 1'b0; trig = 2'b00; pulse_evt = 1'b0;
    bus_wr = 1'b0; bus_rd = 1'b0; bus_addr = 3'd0; bus_wdata = 32'd0;
    s_wr = 1'b0; s_rd = 1'b0; s_addr = 3'd0;
    step(3);
    chk("R6 irq in reset", {63'd0, irq}, 64'd0);
    bread(REG_STATUS, 1'b0, v);
    chk("R3 status in reset", {32'd0, v}, 64'd0);
    rst_n = 1'b1;
    step(4);
    bread(REG_EVENT, 1'b0, v);
    chk("R6 event after reset", {32'd0, v}, 64'd0);
    bread(REG_MASK, 1'b0, v);
    chk("R6 mask after reset", {32'd0, v}, 64'd0);

    // vector table: event, mask and interrupt behaviour
    for (int i = 0; i < NVEC; i++) begin
      case (VEC[i].kind)
        2'd0: bwrite(VEC[i].addr, {29'd0, VEC[i].data});
        2'd1: begin
          bread(VEC[i].addr, 1'b0, v);
          nchk++;
          if (v !== {29'd0, VEC[i].data}) begin
            nfail++;
            $display("FAIL R%0d vector %0d actual=%h expected=%h", VEC[i].req, i, v, VEC[i].data);
          end
        end
        2'd2: begin
          pulse_evt = 1'b1;
          @(negedge clk);
          pulse_evt = 1'b0;
        end
        default: begin
          nchk++;
          if (irq !== VEC[i].data[0]) begin
            nfail++;
            $display("FAIL R%0d vector %0d actual=%b expected=%b", VEC[i].req, i, irq, VEC[i].data[0]);
          end
          @(negedge clk);
        end
      endcase
    end

    // R1 R4 R10: single capture on channel 0
    fire(0, t0);
    bread(REG_EVENT, 1'b0, v);
    chk("R4 channel 0 event", {32'd0, v}, 64'd1);
    bread(REG_STATUS, 1'b0, v);
    chk("R3 channel 0 valid", {32'd0, v}, 64'd1);
    bread(REG_CH0_LO, 1'b1, v);
    bread(REG_CH0_LO, 1'b1, v2);
    chk("R10 repeated low read", {32'd0, v2}, {32'd0, v});
    bread(REG_STATUS, 1'b0, v);
    chk("R10 low read keeps entry", {32'd0, v}, 64'd1);
    rd_ts(0, ts);
    chk("R1 captured count", ts, t0 + 64'd2);
    bread(REG_STATUS, 1'b0, v);
    chk("R3 empty after read", {32'd0, v}, 64'd0);
    srd_ts(0, ts);
    chk("R12 single holds value", ts, t0 + 64'd2);
    bwrite(REG_EVENT, 32'd7);

    // R2 R3 R12: three captures on channel 1
    for (int k = 0; k < 3; k++) fire(1, tl[k]);
    bread(REG_STATUS, 1'b0, v);
    chk("R3 only channel 1 valid", {32'd0, v}, 64'd2);
    bread(REG_EVENT, 1'b0, v);
    chk("R4 channel 1 event", {32'd0, v}, 64'd2);
    srd_ts(1, ts);
    chk("R12 first capture kept", ts, tl[0] + 64'd2);
    sread(REG_STATUS, 1'b0, v);
    chk("R12 later captures dropped", {32'd0, v}, 64'd0);
    for (int k = 0; k < 3; k++) begin
      rd_ts(1, ts);
      chk("R2 oldest first", ts, tl[k] + 64'd2);
    end
    bread(REG_STATUS, 1'b0, v);
    chk("R2 drained", {32'd0, v}, 64'd0);
    bwrite(REG_EVENT, 32'd7);

    // R5: one more capture than the queue holds
    for (int k = 0; k < 5; k++) fire(0, tl[k]);
    for (int k = 0; k < 4; k++) begin
      rd_ts(0, ts);
      chk("R5 stored entries unchanged", ts, tl[k] + 64'd2);
    end
    bread(REG_STATUS, 1'b0, v);
    chk("R5 extra capture dropped", {32'd0, v}, 64'd0);
    bread(REG_CH0_LO, 1'b0, v);
    chk("R10 empty low read is zero", {32'd0, v}, 64'd0);
    srd_ts(0, ts);
    chk("R12 single keeps first of five", ts, tl[0] + 64'd2);
    bwrite(REG_EVENT, 32'd7);
    step(2);
    chk("R6 irq idle at end", {63'd0, irq}, 64'd0);

    report();
    $finish;
  end
endmodule